// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 2^17 bytes. The RAM has a select pair: an active-low enable and an active-high enable. It also has an active-low write strobe and an active-low output enable. The host raises a request with an address, a direction and write data. The sequencer then plays one complete RAM access, built from clock-cycle counts that the package derives from nanosecond limits at the configured clock period.

Each access runs in four phases: idle, setup, strobe and recover. The host's request is captured at acceptance and does not move until the access finishes. Ready stays low for the whole access. A read returns its byte with a one-cycle valid pulse.

The data bus is split into an output value, a drive enable and an input value, so that the tri-state buffer stays outside. A build-time choice decides how the RAM output enable behaves during writes. In the default form it is held high. In the alternative form it stays low and the write strobe is lengthened so the RAM can release the bus before write data appears.

Top module: `sram_strobe_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, ready is 1, both enables are inactive (ram_sel_n=1, ram_sel=0), ram_we_n=1, ram_oe_n=1, ram_dq_oe=0 and rd_valid=0.
- R2: A request is taken only in a cycle where ready is 1. A request held while ready is 0 starts nothing and writes nothing.
- R3: Address, direction and write data are captured at acceptance and stay constant until ready returns. ram_addr never changes while ram_we_n is 0.
- R4: With the output enable held high during writes, ram_we_n is low for exactly max(ceil(tWP), ceil(tAW)-1, ceil(tDW)-1) cycles, which is 7 at 8 ns.
- R5: With the output enable held low during writes, ram_oe_n is 0 in write setup and strobe. The strobe lasts max(R4 value, ceil(tWHZ)+ceil(tDW), floor((tWHZ+tDW)/T)+1) cycles, which is 8 at 8 ns. Data is driven only from strobe cycle ceil(tWHZ) onward.
- R6: With the output enable held high during writes, ram_dq_oe is 1 only while ram_oe_n is 1. It covers write setup, the whole strobe and the first recover cycle.
- R7: The controller and the RAM never drive the bus in the same cycle. The controller releases the bus at least one cycle before the RAM is enabled to drive it.
- R8: A read has one setup cycle with ram_oe_n=1, then ram_oe_n=0 for max(ceil(tAA)-1, ceil(tOE)) cycles (8 at 8 ns). Data is sampled at the end of that window and shown on rd_data with rd_valid high for exactly one cycle, in the first recover cycle.
- R9: Ready is low for 1+S+max(2, ceil(tWC)-1-S) cycles after a write acceptance, and for 1+S+max(1, ceil(tRC)-1-S) cycles after a read acceptance, where S is the strobe length.
- R10: The two enables always change together (ram_sel_n equals the inverse of ram_sel). They are active only in setup and strobe, and ram_we_n is 0 only while they are active.
- R11: Write data is stable on the bus for at least ceil(tDW) strobe cycles before the write strobe ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | Idle and able to take a request |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| ram_addr | output | 17 | RAM address |
| ram_sel_n | output | 1 | RAM active-low enable |
| ram_sel | output | 1 | RAM active-high enable |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_out | output | 8 | Byte for the external bus buffer |
| ram_dq_oe | output | 1 | Drive enable of the bus buffer |
| ram_dq_in | input | 8 | Byte read from the bus |

## Verification
The bench runs both output-enable forms side by side against RAM models. These models return garbage before the access and output-enable deadlines. They also measure the write strobe length, the address age at the end of a write, and how long the write data was stable. A strobe one cycle short shows up as a wrong pulse length or a failed address-age check. A read sampled one cycle early returns garbage instead of the stored byte. A bus driven too early in the output-enable-low form, or held into a following read, is reported as contention. Requests held during a busy access, and writes followed at once by reads of the same address, expose designs that accept early or turn the bus around late.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETUP   = 2'd1,
        PH_STROBE  = 2'd2,
        PH_RECOVER = 2'd3
    } phase_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } ram_pins_t;

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // strobe length of a write in cycles
    function automatic int wr_strobe_cyc(input int clk_ns, input int wp_ns, input int aw_ns,
                                         input int dw_ns, input int whz_ns, input int oe_low);
        int len;
        len = max2(ns_to_cyc(wp_ns, clk_ns), ns_to_cyc(aw_ns, clk_ns) - 1);
        len = max2(len, ns_to_cyc(dw_ns, clk_ns) - 1);
        len = max2(len, 1);
        if (oe_low != 0) begin
            len = max2(len, ns_to_cyc(whz_ns, clk_ns) + ns_to_cyc(dw_ns, clk_ns));
            len = max2(len, (whz_ns + dw_ns) / clk_ns + 1);
        end
        return len;
    endfunction

    // output-enable window of a read in cycles (one setup cycle precedes it)
    function automatic int rd_strobe_cyc(input int clk_ns, input int aa_ns, input int oe_ns);
        return max2(max2(ns_to_cyc(aa_ns, clk_ns) - 1, ns_to_cyc(oe_ns, clk_ns)), 1);
    endfunction

    function automatic int recover_cyc(input int clk_ns, input int cycle_ns,
                                       input int strobe, input int floor_cyc);
        return max2(floor_cyc, ns_to_cyc(cycle_ns, clk_ns) - 1 - strobe);
    endfunction

endpackage

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              in_wr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              wr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (take) begin
            wr_q    <= in_wr;
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
        end
    end

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
    import sram_seq_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int WR_STROBE = 7,
    parameter int WR_RECOV  = 2,
    parameter int RD_STROBE = 8,
    parameter int RD_RECOV  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             wr_q,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             ready,
    output logic             take,
    output logic             sample
);

    localparam logic [CNT_W-1:0] WR_STR_LAST = CNT_W'(WR_STROBE - 1);
    localparam logic [CNT_W-1:0] RD_STR_LAST = CNT_W'(RD_STROBE - 1);
    localparam logic [CNT_W-1:0] WR_REC_LAST = CNT_W'(WR_RECOV - 1);
    localparam logic [CNT_W-1:0] RD_REC_LAST = CNT_W'(RD_RECOV - 1);

    assign ready  = (phase == PH_IDLE);
    assign take   = req && ready;
    assign sample = (phase == PH_STROBE) && (cnt == '0) && !wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (take) begin
                        phase <= PH_SETUP;
                        cnt   <= '0;
                    end
                end
                PH_SETUP: begin
                    phase <= PH_STROBE;
                    cnt   <= wr_q ? WR_STR_LAST : RD_STR_LAST;
                end
                PH_STROBE: begin
                    if (cnt == '0) begin
                        phase <= PH_RECOVER;
                        cnt   <= wr_q ? WR_REC_LAST : RD_REC_LAST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RECOVER: begin
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R9
    setup_single_chk: assert property (@(posedge clk) disable iff (rst)
        phase == PH_SETUP |=> phase == PH_STROBE);

    // R2
    busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !ready);

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
    import sram_seq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int KEEP_OE_LOW = 0,
    parameter int WR_STROBE   = 7,
    parameter int WR_RECOV    = 2,
    parameter int WHZ_CYC     = 4
) (
    input  phase_e            phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wr_q,
    input  logic [DATA_W-1:0] wdata_q,
    output ram_pins_t         pins,
    output logic [DATA_W-1:0] dq_out
);

    logic selected;
    logic wr_strobe;
    logic rd_strobe;
    logic bus_drive;
    logic oe_pin_n;

    always_comb begin
        selected  = (phase == PH_SETUP) || (phase == PH_STROBE);
        wr_strobe = (phase == PH_STROBE) && wr_q;
        rd_strobe = (phase == PH_STROBE) && !wr_q;
    end

    generate
        if (KEEP_OE_LOW != 0) begin : g_oe_low
            // drive only once the RAM has released the bus after the strobe fell
            localparam logic [CNT_W-1:0] LATE_CNT = CNT_W'(WR_STROBE - 1 - WHZ_CYC);
            assign bus_drive = wr_strobe && (cnt <= LATE_CNT);
            assign oe_pin_n  = !(rd_strobe || (selected && wr_q));
        end else begin : g_oe_high
            localparam logic [CNT_W-1:0] HOLD_CNT = CNT_W'(WR_RECOV - 1);
            assign bus_drive = wr_q && (selected || ((phase == PH_RECOVER) && (cnt == HOLD_CNT)));
            assign oe_pin_n  = !rd_strobe;
        end
    endgenerate

    assign pins = '{sel_n: !selected, sel: selected, we_n: !wr_strobe,
                    oe_n: oe_pin_n, dq_oe: bus_drive};
    assign dq_out = wdata_q;

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int CLK_NS      = 8,
    parameter int KEEP_OE_LOW = 0,
    parameter int T_WC_NS     = 70,
    parameter int T_WP_NS     = 45,
    parameter int T_AW_NS     = 60,
    parameter int T_DW_NS     = 30,
    parameter int T_WHZ_NS    = 25,
    parameter int T_RC_NS     = 70,
    parameter int T_AA_NS     = 70,
    parameter int T_OE_NS     = 35
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_sel_n,
    output logic              ram_sel,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);

    localparam int WR_STROBE = wr_strobe_cyc(CLK_NS, T_WP_NS, T_AW_NS, T_DW_NS, T_WHZ_NS, KEEP_OE_LOW);
    localparam int WR_RECOV  = recover_cyc(CLK_NS, T_WC_NS, WR_STROBE, 2);
    localparam int RD_STROBE = rd_strobe_cyc(CLK_NS, T_AA_NS, T_OE_NS);
    localparam int RD_RECOV  = recover_cyc(CLK_NS, T_RC_NS, RD_STROBE, 1);
    localparam int WHZ_CYC   = ns_to_cyc(T_WHZ_NS, CLK_NS);
    localparam int CNT_MAX   = max2(max2(WR_STROBE, RD_STROBE), max2(WR_RECOV, RD_RECOV));
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic              take;
    logic              sample;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    ram_pins_t         pins;

    sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .take(take),
        .in_wr(host_wr), .in_addr(host_addr), .in_wdata(host_wdata),
        .wr_q(wr_q), .addr_q(ram_addr), .wdata_q(wdata_q)
    );

    sram_phase_fsm #(
        .CNT_W(CNT_W), .WR_STROBE(WR_STROBE), .WR_RECOV(WR_RECOV),
        .RD_STROBE(RD_STROBE), .RD_RECOV(RD_RECOV)
    ) u_fsm (
        .clk(clk), .rst(rst), .req(host_req), .wr_q(wr_q),
        .phase(phase), .cnt(cnt), .ready(host_ready), .take(take), .sample(sample)
    );

    sram_pin_decode #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .KEEP_OE_LOW(KEEP_OE_LOW),
        .WR_STROBE(WR_STROBE), .WR_RECOV(WR_RECOV), .WHZ_CYC(WHZ_CYC)
    ) u_pins (
        .phase(phase), .cnt(cnt), .wr_q(wr_q), .wdata_q(wdata_q),
        .pins(pins), .dq_out(ram_dq_out)
    );

    assign ram_sel_n = pins.sel_n;
    assign ram_sel   = pins.sel;
    assign ram_we_n  = pins.we_n;
    assign ram_oe_n  = pins.oe_n;
    assign ram_dq_oe = pins.dq_oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= sample;
            if (sample) rd_data <= ram_dq_in;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> host_ready && ram_sel_n && !ram_sel && ram_we_n && ram_oe_n && !ram_dq_oe && !rd_valid);

    // R3
    addr_still_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> $stable(ram_addr));

    // R3
    addr_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !host_ready && !take |=> $stable(ram_addr));

    // R6
    drive_oe_high_chk: assert property (@(posedge clk) disable iff (rst)
        (KEEP_OE_LOW != 0) || !ram_dq_oe || ram_oe_n);

    // R7
    no_fight_chk: assert property (@(posedge clk) disable iff (rst)
        ram_dq_oe |-> !(!ram_sel_n && ram_sel && !ram_oe_n && ram_we_n));

    // R7
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        (!ram_sel_n && !ram_oe_n && ram_we_n && $past(ram_oe_n)) |-> !$past(ram_dq_oe));

    // R10
    sel_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_sel_n != ram_sel) && (!ram_we_n -> ram_sel));

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

// File: tb/sram_bench_model.sv
module sram_bench_model #(
    parameter int AA_C   = 9,
    parameter int OE_C   = 5,
    parameter int WHZ_C  = 4,
    parameter int DW_C   = 4,
    parameter int AW_C   = 8,
    parameter int WP_MIN = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [16:0] addr,
    input  logic        sel_n,
    input  logic        sel,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [7:0]  ctl_dq,
    input  logic        ctl_oe,
    output logic [7:0]  ram_dq,
    output logic        ram_drv,
    output int          err_addr,
    output int          err_wp,
    output int          err_fight,
    output int          err_setup,
    output int          err_aw,
    output int          last_wp
);
    logic [7:0]  mem [int];
    logic [16:0] a_last;
    int          a_age, o_age, wz, dcnt, aw_seen;
    logic [7:0]  wdat;
    logic [16:0] waddr;
    logic        prev_ctl_oe, prev_rd;
    logic        on, rd_cond, wr_act;

    always_comb begin
        on      = !sel_n && sel;
        rd_cond = on && !oe_n && we_n;
        wr_act  = on && !we_n;
        ram_drv = rd_cond || (wr_act && !oe_n && (wz < WHZ_C));
    end

    always @(negedge clk) begin
        if (rd_cond && (addr == a_last) && (a_age + 1 >= AA_C) && (o_age + 1 >= OE_C))
            ram_dq <= mem.exists(int'(addr)) ? mem[int'(addr)] : 8'h00;
        else
            ram_dq <= 8'hEE;
    end

    always @(posedge clk) begin
        if (rst) begin
            a_last = '0; a_age = 0; o_age = 0; wz = 0; dcnt = 0; aw_seen = 0;
            err_addr = 0; err_wp = 0; err_fight = 0; err_setup = 0; err_aw = 0; last_wp = 0;
            prev_ctl_oe = 1'b0; prev_rd = 1'b0; wdat = '0; waddr = '0;
        end else begin
            if (ctl_oe && ram_drv) err_fight++;
            if (prev_ctl_oe && rd_cond && !prev_rd) err_fight++;
            if (wr_act) begin
                if (wz > 0 && addr != a_last) err_addr++;
                if (ctl_oe && dcnt > 0 && ctl_dq == wdat) dcnt++;
                else if (ctl_oe) dcnt = 1;
                else dcnt = 0;
                wdat = ctl_dq;
                waddr = addr;
                aw_seen = (addr == a_last) ? a_age + 1 : 0;
            end else if (wz > 0) begin
                last_wp = wz;
                if (wz < WP_MIN) err_wp++;
                if (dcnt < DW_C) err_setup++;
                if (aw_seen < AW_C) err_aw++;
                mem[int'(waddr)] = wdat;
                dcnt = 0;
            end
            wz = wr_act ? wz + 1 : 0;
            o_age = rd_cond ? o_age + 1 : 0;
            if (addr != a_last) a_age = 1;
            else if (a_age < 1000) a_age++;
            a_last = addr;
            prev_ctl_oe = ctl_oe;
            prev_rd = rd_cond;
        end
    end
endmodule

// File: tb/sram_strobe_seq_test.sv
module sram_strobe_seq_test;
    localparam int T = 8;

    function automatic int cdiv(input int ns);
        return (ns + T - 1) / T;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // expected timings from the requirements
    localparam int WS0  = mx(mx(cdiv(45), cdiv(60) - 1), cdiv(30) - 1);              // R4
    localparam int WS1  = mx(mx(WS0, cdiv(25) + cdiv(30)), (25 + 30) / T + 1);       // R5
    localparam int RS   = mx(cdiv(70) - 1, cdiv(35));                                // R8
    localparam int RREC = mx(1, cdiv(70) - 1 - RS);
    localparam int WB0  = 1 + WS0 + mx(2, cdiv(70) - 1 - WS0);                       // R9
    localparam int WB1  = 1 + WS1 + mx(2, cdiv(70) - 1 - WS1);
    localparam int RB   = 1 + RS + RREC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(T / 2) clk = ~clk;

    logic        req = 1'b0, wr = 1'b0;
    logic [16:0] haddr = '0;
    logic [7:0]  hdata = '0;

    logic        rdy [2];
    logic        rv [2];
    logic [7:0]  rd [2];
    logic [16:0] ra [2];
    logic        sn [2], s [2], wen [2], oen [2], doe [2], mdrv [2];
    logic [7:0]  dqo [2], mdq [2], dqi [2];
    int          e_addr [2], e_wp [2], e_fight [2], e_setup [2], e_aw [2], lwp [2];

    sram_strobe_seq #(.CLK_NS(T), .KEEP_OE_LOW(0)) uut (
        .clk(clk), .rst(rst), .host_req(req), .host_wr(wr), .host_addr(haddr), .host_wdata(hdata),
        .host_ready(rdy[0]), .rd_data(rd[0]), .rd_valid(rv[0]), .ram_addr(ra[0]),
        .ram_sel_n(sn[0]), .ram_sel(s[0]), .ram_we_n(wen[0]), .ram_oe_n(oen[0]),
        .ram_dq_out(dqo[0]), .ram_dq_oe(doe[0]), .ram_dq_in(dqi[0]));

    sram_strobe_seq #(.CLK_NS(T), .KEEP_OE_LOW(1)) uut_oelow (
        .clk(clk), .rst(rst), .host_req(req), .host_wr(wr), .host_addr(haddr), .host_wdata(hdata),
        .host_ready(rdy[1]), .rd_data(rd[1]), .rd_valid(rv[1]), .ram_addr(ra[1]),
        .ram_sel_n(sn[1]), .ram_sel(s[1]), .ram_we_n(wen[1]), .ram_oe_n(oen[1]),
        .ram_dq_out(dqo[1]), .ram_dq_oe(doe[1]), .ram_dq_in(dqi[1]));

    sram_bench_model #(.AA_C(cdiv(70)), .OE_C(cdiv(35)), .WHZ_C(cdiv(25)), .DW_C(cdiv(30)),
                       .AW_C(cdiv(60)), .WP_MIN(cdiv(45))) mdl0 (
        .clk(clk), .rst(rst), .addr(ra[0]), .sel_n(sn[0]), .sel(s[0]), .we_n(wen[0]), .oe_n(oen[0]),
        .ctl_dq(dqo[0]), .ctl_oe(doe[0]), .ram_dq(mdq[0]), .ram_drv(mdrv[0]),
        .err_addr(e_addr[0]), .err_wp(e_wp[0]), .err_fight(e_fight[0]), .err_setup(e_setup[0]),
        .err_aw(e_aw[0]), .last_wp(lwp[0]));

    sram_bench_model #(.AA_C(cdiv(70)), .OE_C(cdiv(35)), .WHZ_C(cdiv(25)), .DW_C(cdiv(30)),
                       .AW_C(cdiv(60)), .WP_MIN((25 + 30) / T + 1)) mdl1 (
        .clk(clk), .rst(rst), .addr(ra[1]), .sel_n(sn[1]), .sel(s[1]), .we_n(wen[1]), .oe_n(oen[1]),
        .ctl_dq(dqo[1]), .ctl_oe(doe[1]), .ram_dq(mdq[1]), .ram_drv(mdrv[1]),
        .err_addr(e_addr[1]), .err_wp(e_wp[1]), .err_fight(e_fight[1]), .err_setup(e_setup[1]),
        .err_aw(e_aw[1]), .last_wp(lwp[1]));

    always_comb begin
        for (int i = 0; i < 2; i++)
            dqi[i] = mdrv[i] ? mdq[i] : (doe[i] ? dqo[i] : 8'h00);
    end

    int checks = 0;
    int fails  = 0;
    int busy [2];
    logic rd_pend [2];
    logic [7:0] shadow [int];
    logic [7:0] expq [$];
    int rd_pos [2];
    int cycles = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle reference: busy countdown per lane
    always @(posedge clk) begin
        cycles++;
        for (int i = 0; i < 2; i++) begin
            if (rst) begin
                busy[i] = 0;
                rd_pend[i] = 1'b0;
            end else begin
                if (busy[i] > 0) busy[i]--;
                if (req && busy[i] == 0) begin
                    busy[i] = wr ? ((i == 0) ? WB0 : WB1) : RB;
                    rd_pend[i] = !wr;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int i = 0; i < 2; i++) begin
                chk(rdy[i] == (busy[i] == 0), "R9 ready timing", rdy[i], busy[i] == 0);
                chk(rv[i] == (rd_pend[i] && busy[i] == RREC), "R8 rd_valid cycle", rv[i],
                    rd_pend[i] && busy[i] == RREC);
                if (rv[i]) begin
                    if (rd_pos[i] < expq.size()) begin
                        chk(rd[i] == expq[rd_pos[i]], "R8 read data", rd[i], expq[rd_pos[i]]);
                        rd_pos[i]++;
                    end else chk(1'b0, "R8 unexpected read data", rd[i], 0);
                end
                if ((sn[i] == s[i]) || (!wen[i] && !s[i]))
                    chk(1'b0, "R10 enable pairing", {sn[i], s[i], wen[i]}, 3'b101);
            end
            if (doe[0] && !oen[0]) chk(1'b0, "R6 drive with oe low", oen[0], 1);
            if (!wen[1] && oen[1]) chk(1'b0, "R5 oe high during write", oen[1], 0);
        end
    end

    task automatic wait_idle();
        while (!(rdy[0] && rdy[1])) @(negedge clk);
    endtask

    task automatic issue(input bit w, input logic [16:0] a, input logic [7:0] d);
        wait_idle();
        req = 1'b1; wr = w; haddr = a; hdata = d;
        if (w) shadow[int'(a)] = d;
        else expq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
        @(negedge clk);
        req = 1'b0;
        haddr = ~a; hdata = ~d; wr = ~w;   // R3: later host changes must not leak
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        issue(1'b1, a, d);
        wait_idle();
        chk(lwp[0] == WS0, "R4 strobe length", lwp[0], WS0);
        chk(lwp[1] == WS1, "R5 stretched strobe length", lwp[1], WS1);
    endtask

    initial begin : watchdog
        wait (cycles > 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [16:0] lfsr;
        rd_pos[0] = 0; rd_pos[1] = 0;
        repeat (4) @(posedge clk);
        // R1: state during reset
        @(negedge clk);
        for (int i = 0; i < 2; i++)
            chk(rdy[i] && sn[i] && !s[i] && wen[i] && oen[i] && !doe[i] && !rv[i],
                "R1 reset state", {rdy[i], sn[i], s[i], wen[i], oen[i], doe[i], rv[i]}, 7'b1101100);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 2; i++)
            chk(rdy[i] && sn[i] && wen[i] && oen[i] && !doe[i], "R1 after reset",
                {rdy[i], sn[i], wen[i], oen[i], doe[i]}, 5'b11110);

        // basic patterns and address extremes
        do_write(17'h00000, 8'h55);
        do_write(17'h1FFFF, 8'hAA);
        do_write(17'h00100, 8'hFF);
        do_write(17'h0F0F0, 8'h00);
        issue(1'b0, 17'h00000, 8'h00);
        issue(1'b0, 17'h1FFFF, 8'h00);
        issue(1'b0, 17'h00100, 8'h00);
        issue(1'b0, 17'h0F0F0, 8'h00);
        // never-written location
        issue(1'b0, 17'h12345, 8'h00);

        // write then read same address back to back (R7 turnaround)
        do_write(17'h00042, 8'h3C);
        issue(1'b0, 17'h00042, 8'h00);
        wait_idle();

        // R2: request held while busy is ignored
        issue(1'b1, 17'h00777, 8'h81);
        req = 1'b1; wr = 1'b1; haddr = 17'h00999; hdata = 8'h7E;
        repeat (3) @(negedge clk);
        req = 1'b0;
        wait_idle();
        issue(1'b0, 17'h00999, 8'h00);
        issue(1'b0, 17'h00777, 8'h00);

        // mixed traffic
        lfsr = 17'h1ACE1;
        for (int k = 0; k < 24; k++) begin
            lfsr = {lfsr[15:0], lfsr[16] ^ lfsr[13]};
            if (lfsr[0]) do_write(lfsr & 17'h0003F, lfsr[15:8]);
            else issue(1'b0, lfsr & 17'h0003F, 8'h00);
        end
        wait_idle();
        repeat (4) @(negedge clk);

        for (int i = 0; i < 2; i++) begin
            chk(rd_pos[i] == expq.size(), "R8 all reads returned", rd_pos[i], expq.size());
            chk(e_addr[i] == 0, "R3 address moved under strobe", e_addr[i], 0);
            chk(e_wp[i] == 0, "R4 R5 strobe too short", e_wp[i], 0);
            chk(e_aw[i] == 0, "R4 address valid to end of write", e_aw[i], 0);
            chk(e_fight[i] == 0, "R7 bus contention", e_fight[i], 0);
            chk(e_setup[i] == 0, "R11 data setup", e_setup[i], 0);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule